// File: doc/BRIEF.md
# Biphase-Mark Consumer Audio Serializer

This block converts a stream of stereo PCM samples into a single self-clocking serial line in the consumer digital-audio format. Every frame carries a left and then a right sub-frame of 32 slots. A sub-frame starts with a synchronisation preamble, followed by the sample least significant bit first, then four flag bits: validity, user, channel status and parity. Frames are grouped into blocks of 192. A block-start preamble on the first left sub-frame marks where each 192-bit channel-status vector begins.

Samples arrive through a one-entry valid/ready slot. The sample, the validity and user flags and the frame's channel-status bit are all captured only when a new frame begins. A setting changed while a frame is going out therefore never splits a frame, and the frame always matches its parity. If no sample is waiting at a frame boundary, the previous sample is sent again with its validity flag set, so the line never stops. The line rate comes entirely from `cell_en`, a one-cycle pulse at twice the bit rate. The caller generates `cell_en` for the 32, 44.1, 48, 64, 88.2 or 96 kHz sample rate it needs.

Top module: `spdif_tx`

## Requirements
- R1: After reset `spdif_out` is 0 and `s_ready` is 1. The first `cell_en` pulse starts the left sub-frame of frame 0.
- R2: `spdif_out` changes only in the cycle after a `cell_en` pulse. Each slot takes two pulses, so a sub-frame takes 64 pulses, and the left sub-frame always precedes the right.
- R3: Sub-frame layout: slots 0-3 hold the preamble. Sample bit k is in slot 4+k for k = 0..23. Slot 28 is validity, slot 29 is user, slot 30 is channel status and slot 31 is parity.
- R4: In every data slot the line toggles at the start of the slot. It toggles again at mid-slot exactly when the bit is 1.
- R5: Preambles are eight half-slot levels, first in time leftmost, each XORed with the line level just before the preamble. 11101000 marks the left sub-frame of frame 0, 11100010 marks other left sub-frames and 11100100 marks every right sub-frame.
- R6: Slots 4 to 31 of every sub-frame hold an even number of ones.
- R7: Frames are counted modulo 192, and frame 192 carries the block-start preamble again.
- R8: The channel-status slot of both sub-frames of frame n equals `cs_vec[n]`.
- R9: `s_ready` is 1 exactly when the holding slot is empty. An accepted sample is kept and `s_ready` stays 0 until the next frame boundary consumes it.
- R10: At a frame boundary with an empty holding slot, the previous sample pair is sent again with validity 1 in both sub-frames.
- R11: Validity (`s_validity`, used when a new sample is taken) and user (`s_user`) are captured at the frame boundary. Changes or new samples during the left sub-frame do not alter the right sub-frame of the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_en | input | 1 | Half-slot pacing pulse, one cycle wide |
| s_valid | input | 1 | Sample pair offered |
| s_ready | output | 1 | Holding slot empty, offer is accepted |
| s_left | input | 24 | Left PCM sample |
| s_right | input | 24 | Right PCM sample |
| s_validity | input | 1 | Validity flag for a fresh sample pair |
| s_user | input | 1 | User bit for the next frame |
| cs_vec | input | 192 | Channel-status vector, bit n for frame n |
| spdif_out | output | 1 | Biphase-mark encoded line |

## Verification
The hardest case to reach from the ports is a change that lands between the two sub-frames of one frame: a new sample is accepted and the user bit flips after the left half has been latched but before the right half goes out. The bench owns every `cell_en` pulse, so it can stop pacing exactly at the end of a left sub-frame. It then performs the handshake and changes the control inputs, and resumes pacing. It decodes the line back into slots to confirm that the right half still carries the old data and the next frame carries the new data. A full 192-frame pass, with a fresh sample every frame, then reaches the block wrap.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;
  localparam int PRE_SLOTS = 8;
  localparam logic [PRE_SLOTS-1:0] PRE_BLOCK_START = 8'b11101000;
  localparam logic [PRE_SLOTS-1:0] PRE_LEFT_CH     = 8'b11100010;
  localparam logic [PRE_SLOTS-1:0] PRE_RIGHT_CH    = 8'b11100100;

  function automatic logic [PRE_SLOTS-1:0] pick_preamble(input logic is_right,
                                                         input logic is_first);
    if (is_right)      return PRE_RIGHT_CH;
    else if (is_first) return PRE_BLOCK_START;
    else               return PRE_LEFT_CH;
  endfunction
endpackage

// File: rtl/spdif_seq.sv
module spdif_seq #(
  parameter int SF_BITS = 32,
  parameter int FRAMES  = 192,
  localparam int HALVES = 2 * SF_BITS,
  localparam int HC_W   = $clog2(HALVES),
  localparam int FR_W   = $clog2(FRAMES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  output logic [HC_W-1:0] hc,
  output logic            sf_load,
  output logic            fr_load,
  output logic            nxt_right,
  output logic            nxt_first,
  output logic [FR_W-1:0] nxt_frame
);
  logic            sub_q;
  logic [FR_W-1:0] frame_q;

  assign sf_load   = tick && (hc == HC_W'(HALVES - 1));
  assign fr_load   = sf_load && sub_q;
  assign nxt_right = ~sub_q;
  assign nxt_frame = sub_q ? ((frame_q == FR_W'(FRAMES - 1)) ? '0 : frame_q + 1'b1)
                           : frame_q;
  assign nxt_first = (nxt_frame == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hc      <= HC_W'(HALVES - 1);
      sub_q   <= 1'b1;
      frame_q <= FR_W'(FRAMES - 1);
    end else if (tick) begin
      hc <= sf_load ? '0 : hc + 1'b1;
      if (sf_load) begin
        sub_q   <= ~sub_q;
        frame_q <= nxt_frame;
      end
    end
  end

  // R7: frame index moves only at a frame boundary and stays in range
  p_frame_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !fr_load |=> $stable(frame_q));
  p_frame_range_r7: assert property (@(posedge clk) disable iff (rst)
    frame_q <= FR_W'(FRAMES - 1));
endmodule

// File: rtl/spdif_word_build.sv
module spdif_word_build #(
  parameter int SAMPLE_W = 24,
  parameter int FRAMES   = 192,
  localparam int SF_BITS = SAMPLE_W + 8,
  localparam int FR_W    = $clog2(FRAMES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  input  logic                s_validity,
  input  logic                s_user,
  input  logic [FRAMES-1:0]   cs_vec,
  input  logic                fr_load,
  input  logic                sf_load,
  input  logic [FR_W-1:0]     nxt_frame,
  output logic [SF_BITS-1:0]  sf_word
);
  logic                hold_full;
  logic [SAMPLE_W-1:0] hold_l, hold_r, last_l, last_r, cur_l, cur_r;
  logic [SF_BITS-1:0]  right_q;
  logic                v_bit, c_bit, take;

  function automatic logic [SF_BITS-1:0] make_word(input logic [SAMPLE_W-1:0] smp,
                                                   input logic v, input logic u,
                                                   input logic c);
    logic [SF_BITS-1:0] w;
    w                   = '0;
    w[SAMPLE_W+3:4]     = smp;
    w[SAMPLE_W+4]       = v;
    w[SAMPLE_W+5]       = u;
    w[SAMPLE_W+6]       = c;
    w[SF_BITS-1]        = ^w[SF_BITS-2:4];
    return w;
  endfunction

  assign s_ready = ~hold_full;
  assign take    = s_valid && ~hold_full;
  assign cur_l   = hold_full ? hold_l : last_l;
  assign cur_r   = hold_full ? hold_r : last_r;
  assign v_bit   = hold_full ? s_validity : 1'b1;
  assign c_bit   = cs_vec[nxt_frame];
  assign sf_word = fr_load ? make_word(cur_l, v_bit, s_user, c_bit) : right_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full <= 1'b0;
      hold_l    <= '0;
      hold_r    <= '0;
      last_l    <= '0;
      last_r    <= '0;
      right_q   <= '0;
    end else begin
      if (take) begin
        hold_full <= 1'b1;
        hold_l    <= s_left;
        hold_r    <= s_right;
      end else if (fr_load) begin
        hold_full <= 1'b0;
      end
      if (fr_load) begin
        last_l  <= cur_l;
        last_r  <= cur_r;
        right_q <= make_word(cur_r, v_bit, s_user, c_bit);
      end
    end
  end

  // R9: an accepted sample stays put until a frame boundary takes it
  p_hold_kept_r9: assert property (@(posedge clk) disable iff (rst)
    (hold_full && !fr_load) |=> (hold_full && $stable(hold_l) && $stable(hold_r)));
  // R6: every word handed to the encoder carries even parity over slots 4..31
  p_parity_even_r6: assert property (@(posedge clk) disable iff (rst)
    sf_load |-> (^sf_word[SF_BITS-1:4] == 1'b0));
  // R10: underrun forces the validity flag
  p_underrun_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (fr_load && !hold_full) |-> sf_word[SAMPLE_W+4]);
endmodule

// File: rtl/spdif_bmc.sv
module spdif_bmc
  import spdif_tx_pkg::*;
#(
  parameter int SF_BITS = 32,
  localparam int HC_W   = $clog2(2 * SF_BITS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [HC_W-1:0]    hc,
  input  logic               sf_load,
  input  logic               nxt_right,
  input  logic               nxt_first,
  input  logic [SF_BITS-1:0] sf_word,
  output logic               line_q
);
  logic [SF_BITS-1:0]   word_q;
  logic [PRE_SLOTS-1:0] pat_q, pat_n;
  logic                 base_q;
  logic [HC_W-1:0]      nh;

  assign pat_n = pick_preamble(nxt_right, nxt_first);
  assign nh    = hc + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      pat_q  <= '0;
      base_q <= 1'b0;
      line_q <= 1'b0;
    end else if (tick) begin
      if (sf_load) begin
        word_q <= sf_word;
        pat_q  <= pat_n;
        base_q <= line_q;
        line_q <= line_q ^ pat_n[PRE_SLOTS-1];
      end else if (nh < HC_W'(PRE_SLOTS)) begin
        line_q <= base_q ^ pat_q[3'(PRE_SLOTS - 1) - nh[2:0]];
      end else if (!nh[0]) begin
        line_q <= ~line_q;
      end else begin
        line_q <= line_q ^ word_q[nh[HC_W-1:1]];
      end
    end
  end

  // R2: no pacing pulse, no line change
  p_line_still_r2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(line_q));
  // R4: the first half of each data slot differs from the level before it
  p_cell_edge_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && !sf_load && hc[0] && (hc >= HC_W'(PRE_SLOTS - 1))) |=> (line_q != $past(line_q)));
  // R5: every preamble opens with a level change
  p_pre_open_r5: assert property (@(posedge clk) disable iff (rst)
    sf_load |=> (line_q != $past(line_q)));
endmodule

// File: rtl/spdif_tx.sv
module spdif_tx #(
  parameter int SAMPLE_W = 24,
  parameter int FRAMES   = 192
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cell_en,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  input  logic                s_validity,
  input  logic                s_user,
  input  logic [FRAMES-1:0]   cs_vec,
  output logic                spdif_out
);
  localparam int SF_BITS = SAMPLE_W + 8;
  localparam int HC_W    = $clog2(2 * SF_BITS);
  localparam int FR_W    = $clog2(FRAMES);

  logic [HC_W-1:0]    hc;
  logic               sf_load, fr_load, nxt_right, nxt_first;
  logic [FR_W-1:0]    nxt_frame;
  logic [SF_BITS-1:0] sf_word;

  spdif_seq #(.SF_BITS(SF_BITS), .FRAMES(FRAMES)) u_seq (
    .clk(clk), .rst(rst), .tick(cell_en), .hc(hc), .sf_load(sf_load),
    .fr_load(fr_load), .nxt_right(nxt_right), .nxt_first(nxt_first),
    .nxt_frame(nxt_frame)
  );

  spdif_word_build #(.SAMPLE_W(SAMPLE_W), .FRAMES(FRAMES)) u_build (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .s_validity(s_validity),
    .s_user(s_user), .cs_vec(cs_vec), .fr_load(fr_load), .sf_load(sf_load),
    .nxt_frame(nxt_frame), .sf_word(sf_word)
  );

  spdif_bmc #(.SF_BITS(SF_BITS)) u_bmc (
    .clk(clk), .rst(rst), .tick(cell_en), .hc(hc), .sf_load(sf_load),
    .nxt_right(nxt_right), .nxt_first(nxt_first), .sf_word(sf_word),
    .line_q(spdif_out)
  );
endmodule

// File: tb/spdif_tx_test.sv
module spdif_tx_test;
  localparam int CLK_P = 10;
  localparam int NFR   = 192;

  logic clk = 1'b0, rst = 1'b1, cell_en = 1'b0, s_valid = 1'b0;
  logic s_validity = 1'b0, s_user = 1'b0;
  logic [23:0] s_left = '0, s_right = '0;
  logic [NFR-1:0] cs_vec = '0;
  logic s_ready, spdif_out;

  int checks = 0, fails = 0, bfr = 0;
  logic last_lv = 1'b0;
  logic [31:0] wl, wr;
  int kl, kr, bad;
  logic [23:0] exp_l = '0, exp_r = '0;

  always #(CLK_P/2) clk = ~clk;

  spdif_tx uut (.clk(clk), .rst(rst), .cell_en(cell_en), .s_valid(s_valid),
    .s_ready(s_ready), .s_left(s_left), .s_right(s_right), .s_validity(s_validity),
    .s_user(s_user), .cs_vec(cs_vec), .spdif_out(spdif_out));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // decode one sub-frame: 64 pacing pulses, two per slot
  task automatic rx_sub(output logic [31:0] w, output int kind);
    logic lv [64];
    logic [7:0] pat;
    logic prev;
    prev = last_lv;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk) cell_en = 1'b1;
      @(negedge clk) cell_en = 1'b0;
      lv[k] = spdif_out;
    end
    for (int j = 0; j < 8; j++) pat[7-j] = lv[j] ^ prev;
    kind = (pat == 8'b11101000) ? 0 : (pat == 8'b11100010) ? 1 : (pat == 8'b11100100) ? 2 : 3;
    w = '0;
    for (int i = 4; i < 32; i++) begin
      if (lv[2*i] == lv[2*i-1]) bad++;
      w[i] = lv[2*i] ^ lv[2*i+1];
    end
    last_lv = lv[63];
  endtask

  task automatic check_frame(input logic v, input logic u);
    int ek;
    ek = (bfr % NFR == 0) ? 0 : 1;
    chk(kl == ek, "R5/R7 left preamble", 64'(kl), 64'(ek));
    chk(kr == 2, "R5 right preamble", 64'(kr), 64'd2);
    chk(bad == 0, "R4 slot-start toggle", 64'(bad), 64'd0);
    chk(wl[27:4] == exp_l, "R3 left payload", 64'(wl[27:4]), 64'(exp_l));
    chk(wr[27:4] == exp_r, "R3 right payload", 64'(wr[27:4]), 64'(exp_r));
    chk(wl[28] == v && wr[28] == v, "R10/R11 validity", {wl[28], wr[28]}, {v, v});
    chk(wl[29] == u && wr[29] == u, "R11 user", {wl[29], wr[29]}, {u, u});
    chk(wl[30] == cs_vec[bfr % NFR] && wr[30] == cs_vec[bfr % NFR], "R8 channel status",
        {wl[30], wr[30]}, {2{cs_vec[bfr % NFR]}});
    chk(^wl[31:4] == 1'b0 && ^wr[31:4] == 1'b0, "R6 parity", {^wl[31:4], ^wr[31:4]}, 64'd0);
    bfr++;
  endtask

  task automatic rx_frame();
    bad = 0;
    rx_sub(wl, kl);
    rx_sub(wr, kr);
  endtask

  task automatic push(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk);
    chk(s_ready == 1'b1, "R9 ready before push", 64'(s_ready), 64'd1);
    s_valid = 1'b1; s_left = l; s_right = r;
    @(negedge clk);
    s_valid = 1'b0;
    chk(s_ready == 1'b0, "R9 ready low while held", 64'(s_ready), 64'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(spdif_out == 1'b0, "R1 line after reset", 64'(spdif_out), 64'd0);
    chk(s_ready == 1'b1, "R1 ready after reset", 64'(s_ready), 64'd1);
  endtask

  task automatic t_first_underrun();
    rx_frame();
    check_frame(1'b1, 1'b0); // R1 frame 0 block start, R10 repeat of zero sample
  endtask

  task automatic t_sample();
    s_validity = 1'b0; s_user = 1'b1;
    push(24'hABCDEF, 24'h123456);
    exp_l = 24'hABCDEF; exp_r = 24'h123456;
    rx_frame();
    check_frame(1'b0, 1'b1);
    chk(s_ready == 1'b1, "R9 ready after consume", 64'(s_ready), 64'd1);
  endtask

  task automatic t_repeat();
    rx_frame();
    check_frame(1'b1, 1'b1); // R10 same sample again, validity forced
  endtask

  task automatic t_midframe();
    s_user = 1'b0; s_validity = 1'b0;
    push(24'h00F00F, 24'h800001);
    exp_l = 24'h00F00F; exp_r = 24'h800001;
    bad = 0;
    rx_sub(wl, kl);
    s_user = 1'b1;
    push(24'h5A5A5A, 24'hFFFFFF); // R11 arrives mid-frame
    rx_sub(wr, kr);
    check_frame(1'b0, 1'b0);
    exp_l = 24'h5A5A5A; exp_r = 24'hFFFFFF;
    rx_frame();
    check_frame(1'b0, 1'b1);
  endtask

  task automatic t_block();
    for (int f = bfr; f < NFR; f++) begin
      logic [23:0] a, b;
      a = 24'(f * 40503); b = ~24'(f * 977);
      s_user = f[0]; s_validity = f[1];
      push(a, b);
      exp_l = a; exp_r = b;
      rx_frame();
      check_frame(f[1], f[0]);
    end
    s_user = 1'b0;
    rx_frame(); // R7 wrap to block start with cs_vec[0]
    check_frame(1'b1, 1'b0);
  endtask

  task automatic t_stall();
    logic hold;
    hold = spdif_out;
    repeat (30) @(negedge clk);
    chk(spdif_out == hold, "R2 line still without pacing", 64'(spdif_out), 64'(hold));
  endtask

  initial begin
    for (int n = 0; n < NFR; n++) cs_vec[n] = ((n * 5) % 7) < 3;
    t_reset();
    t_first_underrun();
    t_sample();
    t_repeat();
    t_midframe();
    t_block();
    t_stall();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule